// File: doc/BRIEF.md
# Weighted Round Robin Port Arbiter

This block decides which of four ingress ports may send the next transfer toward the upstream port. Each port raises a request line. The arbiter drives at most one grant bit, and the consumer confirms the transfer by raising `accept` in the same cycle as the grant. The grant is combinational from the requests and the registered arbitration state. The arbitration state changes only on a clock edge where a grant is accepted.

Software chooses between two policies with `wrr_mode`.

- **Plain round robin:** the port granted last drops to the lowest priority.
- **Table-driven weighted round robin:** a 32-entry phase table names the port that owns each arbitration period. A port listed in more phases gets a larger share of the link.

The table is written a 32-bit word at a time into a shadow copy. A load strobe requests that the shadow be copied into the active table. The copy happens at the next phase-0 boundary, and a status output reports whether the active table matches the last written contents.

Top module: `wrr_port_arbiter`

## Requirements
- R1: `grant` is one-hot or zero, and a bit of `grant` is set only while the matching bit of `req` is set.
- R2: With `wrr_mode`=0, the arbiter grants the first requesting port found by searching upward from the port after the last accepted round-robin grant, wrapping from 3 to 0. After reset the last-granted port is 3, so port 0 has the highest priority.
- R3: With `wrr_mode`=1, the arbiter grants the owner of the first phase, at or after the phase pointer (wrapping from 31 to 0), whose owner is requesting. Phases whose owner is idle are skipped within the same cycle. If no owner in any of the 32 phases is requesting, there is no grant.
- R4: A phase entry holding a value of 4 or more names no port and is skipped as an empty phase.
- R5: In weighted mode, the phase pointer becomes (granted phase + 1) mod 32 on each cycle where the grant is accepted, and it holds otherwise. `phase_idx` shows the granted phase, or the pointer when there is no weighted grant.
- R6: Table word w, bits 4k+3:4k, hold phase 8w+k; for example, phase 26 is word 3, bits 11:8. A table write changes only the shadow copy and has no effect on grants until the shadow copy is applied.
- R7: The shadow copy is applied to the active table at a clock edge where a load is pending (the strobe is high in this cycle or was seen earlier) and the pointer's next value is 0. `tbl_coherent` goes to 0 after any table write and to 1 after an apply that has no write in the same cycle.
- R8: After reset, phase p is owned by port p mod 4 in both copies, the pointer is 0, no load is pending, and `tbl_coherent` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 4 | Per-port request lines |
| accept | input | 1 | The current grant is taken this cycle |
| wrr_mode | input | 1 | 0 selects round robin, 1 selects the weighted table |
| tbl_wr_en | input | 1 | Write one shadow table word |
| tbl_wr_addr | input | 2 | Shadow word index |
| tbl_wr_data | input | 32 | Eight 4-bit phase owners |
| tbl_load | input | 1 | Request that the shadow be applied at the next phase-0 boundary |
| tbl_coherent | output | 1 | Active table equals the last written table (meaningful in weighted mode) |
| grant | output | 4 | One-hot grant |
| phase_idx | output | 5 | Granted phase, or the phase pointer |

## Verification
A table apply can fall in the same cycle as an accepted grant that wraps the pointer to 0, and a shadow write can fall in the same cycle as that apply. The bench provokes both situations. It keeps traffic flowing while the load strobe is pending, and it drives random writes and strobes during continuous random grants. A behavioural model applies the old shadow contents, then lets the write clear the status, and compares grant, phase and status on every cycle.

// File: rtl/wrr_arb_pkg.sv
// Shared types for the weighted round robin port arbiter.
// Assumes nothing beyond the 2017 language standard.
package wrr_arb_pkg;
    typedef enum logic {
        ARB_MODE_RR  = 1'b0,
        ARB_MODE_WRR = 1'b1
    } arb_mode_e;
endpackage

// File: rtl/wrr_phase_table.sv
// Shadow and active phase tables with deferred apply and coherence status.
// Assumes NUM_PHASES*ID_W is a whole multiple of WORD_W. The apply is
// gated by at_phase0, which the owner drives when the pointer's next value is 0.
module wrr_phase_table #(
    parameter int unsigned NUM_PORTS  = 4,
    parameter int unsigned NUM_PHASES = 32,
    parameter int unsigned ID_W       = 4,
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned ADDR_W     = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [WORD_W-1:0]            wr_data,
    input  logic                         load_req,
    input  logic                         at_phase0,
    output logic [NUM_PHASES*ID_W-1:0]   active_tbl,
    output logic                         coherent
);
    localparam int unsigned TBL_BITS = NUM_PHASES * ID_W;

    // Reset contents: phase p belongs to port p mod NUM_PORTS
    function automatic logic [TBL_BITS-1:0] default_tbl();
        logic [TBL_BITS-1:0] v;
        v = '0;
        for (int p = 0; p < int'(NUM_PHASES); p++)
            v[p*ID_W +: ID_W] = ID_W'(p % int'(NUM_PORTS));
        return v;
    endfunction

    logic [TBL_BITS-1:0] shadow_q;
    logic [TBL_BITS-1:0] active_q;
    logic                pend_q;
    logic                coh_q;
    logic                apply;

    assign apply      = (pend_q | load_req) & at_phase0;
    assign active_tbl = active_q;
    assign coherent   = coh_q;

    // Software writes land in the shadow copy only
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= default_tbl();
        else if (wr_en)
            shadow_q[int'(wr_addr)*WORD_W +: WORD_W] <= wr_data;
    end

    // Active copy takes the shadow at a phase-0 boundary with a load pending
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= default_tbl();
        else if (apply)
            active_q <= shadow_q;
    end

    // Load request is held until it can be applied
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else
            pend_q <= apply ? 1'b0 : (pend_q | load_req);
    end

    // Coherence: a write breaks it, an apply restores it
    always_ff @(posedge clk) begin
        if (!rst_n)
            coh_q <= 1'b1;
        else if (wr_en)
            coh_q <= 1'b0;
        else if (apply)
            coh_q <= 1'b1;
    end

    // R7
    write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !coherent);
    // R7
    apply_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && !wr_en) |=> (coherent && active_q == $past(shadow_q)));
    // R6
    shadow_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(active_q));
endmodule

// File: rtl/wrr_phase_scan.sv
// Finds the first phase at or after the pointer whose owner is requesting.
// Owners of NUM_PORTS or more are empty. Purely combinational.
// Assumes NUM_PORTS is at least 2.
module wrr_phase_scan #(
    parameter int unsigned NUM_PORTS  = 4,
    parameter int unsigned NUM_PHASES = 32,
    parameter int unsigned ID_W       = 4,
    parameter int unsigned PH_W       = 5,
    parameter int unsigned PORT_W     = 2
) (
    input  logic [NUM_PHASES*ID_W-1:0] tbl,
    input  logic [NUM_PORTS-1:0]       req,
    input  logic [PH_W-1:0]            ptr,
    output logic                       hit,
    output logic [PH_W-1:0]            hit_phase,
    output logic [PORT_W-1:0]          hit_port
);
    // Walk up to NUM_PHASES entries from the pointer, first match wins
    always_comb begin
        hit       = 1'b0;
        hit_phase = ptr;
        hit_port  = '0;
        for (int k = 0; k < int'(NUM_PHASES); k++) begin
            int ph;
            int owner;
            ph = int'(ptr) + k;
            if (ph >= int'(NUM_PHASES))
                ph = ph - int'(NUM_PHASES);
            owner = int'(tbl[ph*ID_W +: ID_W]);
            if (!hit && owner < int'(NUM_PORTS) && req[owner]) begin
                hit       = 1'b1;
                hit_phase = PH_W'(ph);
                hit_port  = PORT_W'(owner);
            end
        end
    end
endmodule

// File: rtl/wrr_rr_pick.sv
// Plain round robin: searches upward from the port after the last grant.
// Purely combinational.
module wrr_rr_pick #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned PORT_W    = 2
) (
    input  logic [NUM_PORTS-1:0] req,
    input  logic [PORT_W-1:0]    last,
    output logic                 hit,
    output logic [PORT_W-1:0]    port
);
    // Rotating priority: last+1 highest, last lowest
    always_comb begin
        hit  = 1'b0;
        port = '0;
        for (int k = 1; k <= int'(NUM_PORTS); k++) begin
            int idx;
            idx = (int'(last) + k) % int'(NUM_PORTS);
            if (!hit && req[idx]) begin
                hit  = 1'b1;
                port = PORT_W'(idx);
            end
        end
    end
endmodule

// File: rtl/wrr_port_arbiter.sv
// Port arbiter with a software choice of round robin or 32-phase weighted
// round robin. The grant is combinational and is accepted by 'accept' in the
// same cycle. Assumes NUM_PHASES is a power of two and NUM_PORTS >= 2.
module wrr_port_arbiter #(
    parameter int unsigned NUM_PORTS  = 4,
    parameter int unsigned NUM_PHASES = 32,
    parameter int unsigned ID_W       = 4,
    parameter int unsigned WORD_W     = 32,
    localparam int unsigned NUM_WORDS = NUM_PHASES * ID_W / WORD_W,
    localparam int unsigned ADDR_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int unsigned PH_W      = $clog2(NUM_PHASES),
    localparam int unsigned PORT_W    = $clog2(NUM_PORTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PORTS-1:0]  req,
    input  logic                  accept,
    input  logic                  wrr_mode,
    input  logic                  tbl_wr_en,
    input  logic [ADDR_W-1:0]     tbl_wr_addr,
    input  logic [WORD_W-1:0]     tbl_wr_data,
    input  logic                  tbl_load,
    output logic                  tbl_coherent,
    output logic [NUM_PORTS-1:0]  grant,
    output logic [PH_W-1:0]       phase_idx
);
    import wrr_arb_pkg::*;

    arb_mode_e                  mode;
    logic [PH_W-1:0]            ptr_q;
    logic [PH_W-1:0]            ptr_d;
    logic [PORT_W-1:0]          last_q;
    logic [NUM_PHASES*ID_W-1:0] active_tbl;
    logic                       w_hit;
    logic [PH_W-1:0]            w_phase;
    logic [PORT_W-1:0]          w_port;
    logic                       r_hit;
    logic [PORT_W-1:0]          r_port;
    logic                       sel_hit;
    logic [PORT_W-1:0]          sel_port;
    logic                       taken;

    assign mode = arb_mode_e'(wrr_mode);

    wrr_phase_table #(
        .NUM_PORTS(NUM_PORTS), .NUM_PHASES(NUM_PHASES), .ID_W(ID_W),
        .WORD_W(WORD_W), .ADDR_W(ADDR_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr_en), .wr_addr(tbl_wr_addr),
        .wr_data(tbl_wr_data), .load_req(tbl_load), .at_phase0(ptr_d == '0),
        .active_tbl(active_tbl), .coherent(tbl_coherent)
    );

    wrr_phase_scan #(
        .NUM_PORTS(NUM_PORTS), .NUM_PHASES(NUM_PHASES), .ID_W(ID_W),
        .PH_W(PH_W), .PORT_W(PORT_W)
    ) u_scan (
        .tbl(active_tbl), .req(req), .ptr(ptr_q),
        .hit(w_hit), .hit_phase(w_phase), .hit_port(w_port)
    );

    wrr_rr_pick #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_rr (
        .req(req), .last(last_q), .hit(r_hit), .port(r_port)
    );

    // Select the policy's winner and form the one-hot grant
    always_comb begin
        sel_hit  = (mode == ARB_MODE_WRR) ? w_hit  : r_hit;
        sel_port = (mode == ARB_MODE_WRR) ? w_port : r_port;
        grant    = '0;
        if (sel_hit)
            grant[sel_port] = 1'b1;
        phase_idx = (mode == ARB_MODE_WRR && w_hit) ? w_phase : ptr_q;
    end

    assign taken = accept & sel_hit;

    // Next pointer: one past the accepted weighted phase, else unchanged
    always_comb begin
        ptr_d = ptr_q;
        if (taken && mode == ARB_MODE_WRR)
            ptr_d = w_phase + PH_W'(1);
    end

    // Phase pointer register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else
            ptr_q <= ptr_d;
    end

    // Last round-robin winner, which becomes the lowest priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= PORT_W'(NUM_PORTS - 1);
        else if (taken && mode == ARB_MODE_RR)
            last_q <= r_port;
    end

    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R1
    grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);
    // R5
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrr_mode && accept && grant != '0) |=>
        ptr_q == PH_W'((int'($past(phase_idx)) + 1) % int'(NUM_PHASES)));
    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wrr_mode && accept && grant != '0) |=> $stable(ptr_q));
    // R2
    rr_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrr_mode && accept && grant != '0) |=> last_q == $past(sel_port));
endmodule

// File: tb/sim_wrr_port_arbiter.sv
`timescale 1ns/100ps
module sim_wrr_port_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req = '0;
    logic        accept = 1'b0;
    logic        wrr_mode = 1'b0;
    logic        tbl_wr_en = 1'b0;
    logic [1:0]  tbl_wr_addr = '0;
    logic [31:0] tbl_wr_data = '0;
    logic        tbl_load = 1'b0;
    logic        tbl_coherent;
    logic [3:0]  grant;
    logic [4:0]  phase_idx;

    int checks = 0;
    int errors = 0;

    // Reference state
    int sh[32];
    int ac[32];
    int m_ptr, m_last, m_pend, m_coh;

    always #2.5 clk = ~clk;

    wrr_port_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .accept(accept),
        .wrr_mode(wrr_mode), .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr),
        .tbl_wr_data(tbl_wr_data), .tbl_load(tbl_load),
        .tbl_coherent(tbl_coherent), .grant(grant), .phase_idx(phase_idx)
    );

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual hung, expected finished");
        summary();
        $finish;
    end

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, compare against the model, then advance the model
    task automatic step(logic [3:0] r, logic a, logic m, logic we,
                        logic [1:0] wa, logic [31:0] wd, logic ld, string tag);
        int found, port, ph, nptr, apply;
        req = r; accept = a; wrr_mode = m;
        tbl_wr_en = we; tbl_wr_addr = wa; tbl_wr_data = wd; tbl_load = ld;
        #1;
        found = 0; port = 0; ph = m_ptr;
        if (m) begin
            for (int k = 0; k < 32; k++) begin
                int p, o;
                p = (m_ptr + k) % 32;
                o = ac[p];
                if (found == 0 && o < 4 && r[o]) begin
                    found = 1; port = o; ph = p;
                end
            end
        end else begin
            for (int k = 1; k <= 4; k++) begin
                int i;
                i = (m_last + k) % 4;
                if (found == 0 && r[i]) begin
                    found = 1; port = i;
                end
            end
        end
        check(tag, "grant", int'(grant), found ? (1 << port) : 0);
        check(tag, "phase_idx", int'(phase_idx), ph);
        check("R7", "tbl_coherent", int'(tbl_coherent), m_coh);
        @(posedge clk);
        nptr = m_ptr;
        if (found && a) begin
            if (m) nptr = (ph + 1) % 32;
            else   m_last = port;
        end
        apply = (m_pend || ld) && nptr == 0;
        if (apply) for (int i = 0; i < 32; i++) ac[i] = sh[i];
        if (we) for (int i = 0; i < 8; i++) sh[int'(wa)*8 + i] = int'((wd >> (4*i)) & 32'hF);
        m_pend = apply ? 0 : (m_pend || ld);
        m_coh  = we ? 0 : (apply ? 1 : m_coh);
        m_ptr  = nptr;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin sh[i] = i % 4; ac[i] = i % 4; end
        m_ptr = 0; m_last = 3; m_pend = 0; m_coh = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state
        step(4'h0, 0, 1, 0, 0, 0, 0, "R8");
        step(4'h1, 0, 1, 0, 0, 0, 0, "R8");
        // R2: round robin rotation and partial requests
        repeat (6) step(4'hF, 1, 0, 0, 0, 0, 0, "R2");
        repeat (3) step(4'b1010, 1, 0, 0, 0, 0, 0, "R2");
        repeat (2) step(4'b0100, 0, 0, 0, 0, 0, 0, "R2");
        step(4'h0, 1, 0, 0, 0, 0, 0, "R1");
        // R3, R5: weighted mode over a full wrap, then hold without accept
        repeat (40) step(4'hF, 1, 1, 0, 0, 0, 0, "R5");
        repeat (3) step(4'hF, 0, 1, 0, 0, 0, 0, "R5");
        repeat (10) step(4'b1000, 1, 1, 0, 0, 0, 0, "R3");
        // R6: shadow writes, phase 26 at word 3 bits 11:8 owned by port 1
        step(4'b0010, 1, 1, 1, 2'd0, 32'h22222222, 0, "R6");
        step(4'b0010, 1, 1, 1, 2'd1, 32'h22222222, 0, "R6");
        step(4'b0010, 1, 1, 1, 2'd2, 32'h22222222, 0, "R6");
        step(4'b0010, 1, 1, 1, 2'd3, 32'h22222122, 0, "R6");
        repeat (4) step(4'b0010, 1, 1, 0, 0, 0, 0, "R6");
        // R7: strobe, then traffic until the pointer wraps to phase 0
        step(4'b0110, 1, 1, 0, 0, 0, 1, "R7");
        repeat (40) step(4'b0110, 1, 1, 0, 0, 0, 0, "R7");
        repeat (6) step(4'b0010, 1, 1, 0, 0, 0, 0, "R6");
        // R4: only phase 3 names a real port; 0xF entries are empty
        step(4'hF, 0, 1, 1, 2'd0, 32'hFFFF3FFF, 0, "R4");
        step(4'hF, 0, 1, 1, 2'd1, 32'hFFFFFFFF, 0, "R4");
        step(4'hF, 0, 1, 1, 2'd2, 32'hFFFFFFFF, 0, "R4");
        step(4'hF, 0, 1, 1, 2'd3, 32'hFFFFFFFF, 1, "R4");
        repeat (40) step(4'hF, 1, 1, 0, 0, 0, 0, "R7");
        repeat (5) step(4'hF, 1, 1, 0, 0, 0, 0, "R4");
        repeat (3) step(4'b0111, 1, 1, 0, 0, 0, 0, "R4");
        // R1: random mix of modes, requests, writes and loads
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] rnd;
            rnd = $urandom;
            step(rnd[3:0], rnd[4] | rnd[5], (n / 500) % 2 == 0 ? 1'b1 : rnd[6] & rnd[7],
                 rnd[8:6] == 3'b111, rnd[10:9], $urandom, rnd[15:12] == 4'h0, "R1");
        end
        summary();
        $finish;
    end
endmodule